// File: doc/BRIEF.md
# Register-Controlled General-Purpose Pin Bank

This block is a 32-pin general-purpose I/O bank driven from a simple 32-bit register bus. Each pin is either an input or an output. Software changes direction through two write-one registers: one that turns the named pins into outputs and one that turns them back into inputs. Bits written as zero have no effect, so one driver can claim or release pins without a read-modify-write cycle.

Output levels are written one half of the bank at a time. The upper 16 bits of the data word are a per-pin write enable, and the lower 16 bits are the new levels. A single bus write can therefore change one pin and leave its neighbours alone. Each pin's output latch keeps its value while the pin is an input. When the pin is made an output again, it drives that stored level straight away.

The pad levels pass through a two-flop synchronizer before they can be read. The pad drivers are modelled as an output value vector and an output-enable vector. Read data is registered and appears the cycle after the request.

Top module: `pin_bank`

## Requirements
- R1: While reset is asserted and on leaving it, every pin is an input (padOe all zero), every output latch is zero (padOut all zero) and busRdata is zero.
- R2: A write to offset 0x00 sets padOe bit i for every data bit i that is 1. Pins whose data bit is 0 keep their direction. The change is visible the cycle after the write.
- R3: A write to offset 0x04 clears padOe bit i for every data bit i that is 1. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates the latches of pins 0–15. Pin i takes data bit i only where data bit 16+i is 1. All other pins keep their latch value.
- R5: A write to offset 0x0C updates the latches of pins 16–31. Pin 16+j takes data bit j only where data bit 16+j is 1. Pins 0–15 are untouched.
- R6: A pin's latch can be written, and keeps its value, while the pin is an input. In the cycle after the pin is made an output, padOut already shows the stored value and padOe is 1. Output-value writes never change direction.
- R7: A read of offset 0x04 returns the direction vector (1 = output) on busRdata in the cycle after the request.
- R8: A read of offset 0x10 returns the pad levels after two synchronizing flops. A padIn change is not seen by a read issued one clock edge later. It is seen by a read issued two clock edges later.
- R9: The following have no effect on the pins: a write to any other offset (0x10, 0x14, or an address that is not word-aligned), and bus activity while busValid is low. A read of any offset other than 0x04 or 0x10 returns zero.
- R10: busRdata changes only on a valid read and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data, valid the cycle after a read |
| padIn | input | 32 | Pad input levels, asynchronous to clk |
| padOut | output | 32 | Output latch value per pin |
| padOe | output | 32 | Output enable per pin, 1 = drive |

## Verification
The assertions assume a single bus agent. Each request lasts one cycle, so at most one decoded strobe is active at a time. They also assume that reset is released synchronously to the clock. The bench drives every bus field on the falling edge, holds busValid for exactly one cycle per access, and returns it to zero between accesses. It changes padIn only on falling edges, and samples busRdata and the pad vectors on the falling edge after the clock edge that updates them.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  // Register byte offsets; software depends on these values.
  localparam logic [7:0] OFS_MAKE_OUT = 8'h00;
  localparam logic [7:0] OFS_MAKE_IN  = 8'h04;  // also reads back direction
  localparam logic [7:0] OFS_LVL_LO   = 8'h08;
  localparam logic [7:0] OFS_LVL_HI   = 8'h0C;
  localparam logic [7:0] OFS_SAMPLE   = 8'h10;

  // Strobes from the decoder to the datapath, at most one per cycle.
  typedef struct packed {
    logic setDir;
    logic clrDir;
    logic wrLow;
    logic wrHigh;
    logic rdDir;
    logic rdIn;
    logic rdNone;
  } strobe_t;
endpackage

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic isWr, isRd;
  logic hitOut, hitIn, hitLo, hitHi, hitSmp;

  assign isWr   = busValid & busWrite;
  assign isRd   = busValid & ~busWrite;
  assign hitOut = (busAddr == ADDR_W'(OFS_MAKE_OUT));
  assign hitIn  = (busAddr == ADDR_W'(OFS_MAKE_IN));
  assign hitLo  = (busAddr == ADDR_W'(OFS_LVL_LO));
  assign hitHi  = (busAddr == ADDR_W'(OFS_LVL_HI));
  assign hitSmp = (busAddr == ADDR_W'(OFS_SAMPLE));

  always_comb begin
    stb        = '0;
    stb.setDir = isWr & hitOut;
    stb.clrDir = isWr & hitIn;
    stb.wrLow  = isWr & hitLo;
    stb.wrHigh = isWr & hitHi;
    stb.rdDir  = isRd & hitIn;
    stb.rdIn   = isRd & hitSmp;
    stb.rdNone = isRd & ~hitIn & ~hitSmp;
  end

  // R9: decode never raises two strobes together
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R9: an idle bus raises no strobe
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (stb == '0));
endmodule

// File: rtl/pin_bank_dp.sv
module pin_bank_dp
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  localparam int HALF   = NUM_PINS / 2;
  localparam int NHALVES = 2;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] outLat;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] wMask;

  assign wMask = wdata[NUM_PINS-1:0];

  // Direction: write-one set and write-one clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dirReg <= '0;
    else if (stb.setDir) dirReg <= dirReg | wMask;
    else if (stb.clrDir) dirReg <= dirReg & ~wMask;
  end

  // Output latches, one half per register, with per-bit enables from the upper half-word.
  for (genvar h = 0; h < NHALVES; h++) begin : g_half
    logic            wrThis;
    logic [HALF-1:0] en, val;
    assign wrThis = (h == 0) ? stb.wrLow : stb.wrHigh;
    assign en     = wdata[2*HALF-1:HALF];
    assign val    = wdata[HALF-1:0];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       outLat[h*HALF +: HALF] <= '0;
      else if (wrThis) outLat[h*HALF +: HALF] <= (outLat[h*HALF +: HALF] & ~en) | (val & en);
    end
  end

  // Input synchronizer chain.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= (s == 0) ? padIn : syncQ[(s == 0) ? 0 : s-1];
    end
  end

  // Registered read data, updated only on reads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdata <= '0;
    else if (stb.rdDir)  rdata <= DATA_W'(dirReg);
    else if (stb.rdIn)   rdata <= DATA_W'(syncQ[SYNC_STAGES-1]);
    else if (stb.rdNone) rdata <= '0;
  end

  assign padOut = outLat;
  assign padOe  = dirReg;

  // R1: state is cleared when reset releases
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (dirReg == '0 && outLat == '0 && rdata == '0));
  // R2: a set write only adds outputs, and adds every named one
  p_set_adds_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDir |=> (((dirReg & $past(wMask)) == $past(wMask)) && (($past(dirReg) & ~dirReg) == '0)));
  // R3: a clear write only removes outputs, and removes every named one
  p_clr_removes_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrDir |=> (((dirReg & $past(wMask)) == '0) && ((dirReg & ~$past(dirReg)) == '0)));
  // R4: a low-half write leaves the high half alone
  p_low_keeps_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLow |=> $stable(outLat[NUM_PINS-1:HALF]));
  // R5: a high-half write leaves the low half alone
  p_high_keeps_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrHigh |=> $stable(outLat[HALF-1:0]));
  // R6: level writes never touch direction; direction writes never touch latches
  p_lvl_keeps_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLow || stb.wrHigh) |=> $stable(dirReg));
  p_dir_keeps_lvl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setDir || stb.clrDir) |=> $stable(outLat));
  // R10: read data moves only after a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdDir || stb.rdIn || stb.rdNone) |=> $stable(rdata));
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  strobe_t stb;

  pin_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .stb(stb)
  );

  pin_bank_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .rdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/sim_pin_bank.sv
`timescale 1ns/1ps
module sim_pin_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0, padOut, padOe;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [31:0] expDir = '0, expOut = '0, rd;

  always #2 clk = ~clk;

  pin_bank u0 (.clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // One-cycle write; the bench model follows the requirements.
  task automatic doWrite(input logic [7:0] a, input logic [31:0] d, input bit valid = 1);
    busValid = valid; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    if (valid) begin
      case (a)
        8'h00: expDir = expDir | d;
        8'h04: expDir = expDir & ~d;
        8'h08: expOut[15:0]  = (expOut[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
        8'h0C: expOut[31:16] = (expOut[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
        default: ;
      endcase
    end
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic checkPins(input string tag);
    chk({tag, " padOe"}, padOe, expDir);
    chk({tag, " padOut"}, padOut, expOut);
  endtask

  task automatic testReset;
    chk("R1 padOe", padOe, 32'h0);
    chk("R1 padOut", padOut, 32'h0);
    chk("R1 busRdata", busRdata, 32'h0);
  endtask

  task automatic testDirSet;
    doWrite(8'h00, 32'hA5A5_0F0F);
    checkPins("R2 first set");
    doWrite(8'h00, 32'h0000_0030);
    checkPins("R2 second set keeps others");
    doRead(8'h04, rd);
    chk("R7 direction read", rd, 32'hA5A5_0F3F);
  endtask

  task automatic testDirClr;
    doWrite(8'h04, 32'h8000_000F);
    checkPins("R3 clear subset");
    doRead(8'h04, rd);
    chk("R7 direction read after clear", rd, 32'h25A5_0F30);
  endtask

  task automatic testLowHalf;
    doWrite(8'h08, {16'h00FF, 16'h1234});
    checkPins("R4 low byte enabled");
    doWrite(8'h08, {16'hFF00, 16'hABCD});
    checkPins("R4 high byte enabled");
    chk("R4 value", padOut, 32'h0000_AB34);
    doWrite(8'h08, {16'h0000, 16'hFFFF});
    checkPins("R4 no enables");
  endtask

  task automatic testHighHalf;
    doWrite(8'h0C, {16'h8001, 16'hFFFF});
    checkPins("R5 pins 16 and 31");
    chk("R5 value", padOut, 32'h8001_AB34);
  endtask

  task automatic testLatchHold;
    doWrite(8'h04, 32'hFFFF_FFFF);
    checkPins("R6 all inputs");
    doWrite(8'h08, {16'h0003, 16'h0002});
    doWrite(8'h0C, {16'h0100, 16'h0100});
    chk("R6 padOe unchanged by level writes", padOe, 32'h0);
    chk("R6 latch held while input", padOut, expOut);
    doWrite(8'h00, 32'h0100_0002);
    chk("R6 drive enabled at once", padOe, 32'h0100_0002);
    chk("R6 stored value driven", padOut & padOe, 32'h0100_0002);
  endtask

  task automatic testSync;
    padIn = 32'hDEAD_BEEF;
    @(negedge clk);
    doRead(8'h10, rd);
    chk("R8 not yet through synchronizer", rd, 32'h0);
    doRead(8'h10, rd);
    chk("R8 synchronized level", rd, 32'hDEAD_BEEF);
    padIn = 32'h0F0F_1234;
    @(negedge clk); @(negedge clk);
    doRead(8'h10, rd);
    chk("R8 second pattern", rd, 32'h0F0F_1234);
  endtask

  task automatic testIgnored;
    doWrite(8'h14, 32'hFFFF_FFFF);
    doWrite(8'h10, 32'hFFFF_FFFF);
    doWrite(8'h02, 32'hFFFF_FFFF);
    doWrite(8'h09, 32'hFFFF_FFFF);
    doWrite(8'h00, 32'hFFFF_FFFF, 0);
    checkPins("R9 ignored writes");
    doRead(8'h08, rd);
    chk("R9 unmapped read", rd, 32'h0);
  endtask

  task automatic testRdHold;
    doRead(8'h04, rd);
    chk("R10 read direction", rd, expDir);
    repeat (3) @(negedge clk);
    chk("R10 held while idle", busRdata, expDir);
    doWrite(8'h00, 32'h0000_0F00);
    chk("R10 held across write", busRdata, rd);
    chk("R2 set after hold", padOe, expDir);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirSet();
    testDirClr();
    testLowHalf();
    testHighHalf();
    testLatchHold();
    testSync();
    testIgnored();
    testRdHold();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule